// File: doc/BRIEF.md
# Packed Integer Compare-to-Mask Unit

This block compares two packed vectors of 32-bit integer lanes and returns one result bit per lane. A 3-bit relation code picks the relation. Two of the eight codes are constants (always false, always true). The other six are equal, less, less-or-equal and their three complements. One input bit chooses whether lanes are read as two's-complement or as unsigned numbers.

The caller chooses how many lanes are live: 4, 8 or 16. Mask bits above the live lanes always read zero. An optional writemask clears the result bit of any lane whose mask bit is zero. The unit never keeps old destination bits. When the second operand comes from memory and the broadcast flag is set, lane 0 of that operand is compared against every lane of the first operand.

The result is registered. A request marked by `in_valid` gives its mask and `out_valid` one clock later.

Top module: `vcmp_mask_unit`

## Requirements
- R1: `pred_imm[2:0]` selects the relation per lane, comparing A against B. The codes are: 0 A==B, 1 A<B, 2 A<=B, 3 constant 0, 4 A!=B, 5 A>=B, 6 A>B, 7 constant 1.
- R2: Bits `pred_imm[7:3]` are reserved and never change the result.
- R3: When `is_signed`=1, each lane is read as a two's-complement number with bit 31 as its sign. When `is_signed`=0, each lane is read as unsigned. The signedness setting changes no other behaviour.
- R4: Lane j compares `src_a[32j+31:32j]` against the matching lane of B. Result bit j is 1 exactly when the relation holds.
- R5: `vlen_sel` sets the live lane count: 2'b00 gives 4, 2'b01 gives 8, 2'b10 and 2'b11 give 16. Mask bits at or above the live count are 0, and data in lanes above it has no effect.
- R6: When `wmask_en`=1, result bit j is 0 wherever `wmask[j]`=0. When `wmask_en`=0, `wmask` has no effect.
- R7: When `bcast`=1 and `b_is_mem`=1, every lane uses `src_b[31:0]` as its B value. Setting `bcast` alone, with `b_is_mem`=0, has no effect.
- R8: On the clock edge where `in_valid`=1, the new mask appears on `mask_out` and `out_valid` goes high. `out_valid` is low after an edge where `in_valid`=0, and `mask_out` then keeps its previous value.
- R9: A synchronous active-low reset clears `mask_out` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures a new result |
| src_a | input | 512 | First packed operand, 16 lanes of 32 bits |
| src_b | input | 512 | Second packed operand |
| pred_imm | input | 8 | Relation code byte; only bits 2:0 are used |
| is_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| vlen_sel | input | 2 | Live lane count select (4/8/16) |
| wmask_en | input | 1 | Enables zeroing by the writemask |
| wmask | input | 16 | Per-lane writemask |
| bcast | input | 1 | Requests replication of B lane 0 |
| b_is_mem | input | 1 | Marks B as a memory operand; broadcast needs this bit |
| mask_out | output | 16 | Registered per-lane result |
| out_valid | output | 1 | High one cycle after a request |

## Verification
Each lane owns one result bit. A corrupted decode of the relation, a flipped sign bit or a stuck lane gate therefore shows up in a specific bit of `mask_out` on the cycle right after the request. The bench crosses the four boundary values 0x00000000, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF across all sixteen lanes, so one request probes every ordered pair of them. A wrong captured register shows up either as a value that differs from the prediction on the next request, or as a value that changes during idle cycles, when it should hold.

// File: rtl/vcmp_pkg.sv
// Shared definitions for the packed compare unit.
// Assumes lanes are LANE_W bits wide and the relation code is 3 bits.
package vcmp_pkg;

    localparam int unsigned LANE_W = 32;

    // Relation codes carried in the low three bits of the predicate byte.
    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_FALSE = 3'd3,
        PR_NE    = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_TRUE  = 3'd7
    } pred_e;

    // A relation reduced to: (eq & use_eq | lt & use_lt) ^ invert.
    typedef struct packed {
        logic invert;
        logic use_eq;
        logic use_lt;
    } rel_sel_t;

endpackage

// File: rtl/vcmp_pred_decode.sv
// Turns the 3-bit relation code into eq/lt selects plus an invert bit.
// Assumes the caller strips the reserved predicate bits.
module vcmp_pred_decode
    import vcmp_pkg::*;
(
    input  logic [2:0] code,
    output rel_sel_t   sel
);

    // Map the low two bits to the base relation; bit 2 inverts it.
    always_comb begin
        sel.invert = code[2];
        unique case (code[1:0])
            2'b00:   begin sel.use_eq = 1'b1; sel.use_lt = 1'b0; end
            2'b01:   begin sel.use_eq = 1'b0; sel.use_lt = 1'b1; end
            2'b10:   begin sel.use_eq = 1'b1; sel.use_lt = 1'b1; end
            default: begin sel.use_eq = 1'b0; sel.use_lt = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vcmp_lane.sv
// One lane comparator: evaluates the selected relation for a pair of values.
// Assumes signed mode means two's complement; the MSB is flipped so that a
// single unsigned comparator serves both interpretations.
module vcmp_lane
    import vcmp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  rel_sel_t     sel,
    output logic         hit
);

    logic [W-1:0] a_k;
    logic [W-1:0] b_k;
    logic         eq;
    logic         lt;

    // Bias the sign bit so signed order equals unsigned order of the keys.
    always_comb begin
        a_k = {a[W-1] ^ is_signed, a[W-2:0]};
        b_k = {b[W-1] ^ is_signed, b[W-2:0]};
    end

    // Compare the keys and combine the result with the relation selects.
    always_comb begin
        eq  = (a_k == b_k);
        lt  = (a_k <  b_k);
        hit = ((eq & sel.use_eq) | (lt & sel.use_lt)) ^ sel.invert;
    end

endmodule

// File: rtl/vcmp_lane_gate.sv
// Clears result bits of lanes outside the live length or masked off by the
// writemask (zeroing only). Assumes NL is divisible by four.
module vcmp_lane_gate #(
    parameter int unsigned NL = 16
) (
    input  logic [1:0]    vlen_sel,
    input  logic          wmask_en,
    input  logic [NL-1:0] wmask,
    input  logic [NL-1:0] raw,
    output logic [NL-1:0] gated
);

    localparam int unsigned NL_Q = NL / 4;
    localparam int unsigned NL_H = NL / 2;

    logic [NL-1:0] live;

    // Build the live-lane mask from the length select.
    generate
        for (genvar j = 0; j < NL; j++) begin : g_live
            if (j < NL_Q) begin : g_q
                assign live[j] = 1'b1;
            end else if (j < NL_H) begin : g_h
                assign live[j] = (vlen_sel != 2'b00);
            end else begin : g_f
                assign live[j] = vlen_sel[1];
            end
        end
    endgenerate

    // Apply the live mask and, if enabled, the writemask.
    always_comb begin
        gated = raw & live & (wmask_en ? wmask : {NL{1'b1}});
    end

endmodule

// File: rtl/vcmp_mask_unit.sv
// Packed compare-to-mask unit, top level. Compares MAX_LANES lanes of A and B
// under a 3-bit relation code and registers the gated per-lane result.
// Assumes the reset is synchronous and active low; the result appears one
// clock after in_valid.
module vcmp_mask_unit
    import vcmp_pkg::*;
#(
    parameter int unsigned MAX_LANES = 16,
    localparam int unsigned VEC_W    = LANE_W * MAX_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [7:0]           pred_imm,
    input  logic                 is_signed,
    input  logic [1:0]           vlen_sel,
    input  logic                 wmask_en,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 bcast,
    input  logic                 b_is_mem,
    output logic [MAX_LANES-1:0] mask_out,
    output logic                 out_valid
);

    rel_sel_t             sel;
    logic                 use_bcast;
    logic [MAX_LANES-1:0] raw_hits;
    logic [MAX_LANES-1:0] gated_hits;
    logic                 unused_rsvd;
    logic [MAX_LANES-1:0] mask_q;
    logic                 valid_q;

    // Reserved predicate bits are intentionally dropped.
    assign unused_rsvd = ^pred_imm[7:3];

    // Broadcast applies only to a memory-sourced second operand.
    assign use_bcast = bcast & b_is_mem;

    vcmp_pred_decode u_dec (
        .code (pred_imm[2:0]),
        .sel  (sel)
    );

    // One comparator per lane; B comes from its own lane or from lane 0.
    generate
        for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
            logic [LANE_W-1:0] b_lane;
            assign b_lane = use_bcast ? src_b[LANE_W-1:0]
                                      : src_b[j*LANE_W +: LANE_W];
            vcmp_lane #(.W(LANE_W)) u_lane (
                .a         (src_a[j*LANE_W +: LANE_W]),
                .b         (b_lane),
                .is_signed (is_signed),
                .sel       (sel),
                .hit       (raw_hits[j])
            );
        end
    endgenerate

    vcmp_lane_gate #(.NL(MAX_LANES)) u_gate (
        .vlen_sel (vlen_sel),
        .wmask_en (wmask_en),
        .wmask    (wmask),
        .raw      (raw_hits),
        .gated    (gated_hits)
    );

    // Capture the result on a request; the valid flag follows in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) mask_q <= gated_hits;
        end
    end

    assign mask_out  = mask_q;
    assign out_valid = valid_q;

endmodule

// File: rtl/vcmp_mask_unit_chk.sv
// Property checker for vcmp_mask_unit, attached by bind below.
// Assumes the top's default lane geometry (MAX_LANES divisible by four).
module vcmp_mask_unit_chk #(
    parameter int unsigned MAX_LANES = 16,
    parameter int unsigned VEC_W     = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [VEC_W-1:0]     src_a,
    input logic [VEC_W-1:0]     src_b,
    input logic [7:0]           pred_imm,
    input logic [1:0]           vlen_sel,
    input logic                 wmask_en,
    input logic [MAX_LANES-1:0] wmask,
    input logic                 bcast,
    input logic [MAX_LANES-1:0] mask_out,
    input logic                 out_valid
);

    localparam int unsigned QL = MAX_LANES / 4;
    localparam int unsigned HL = MAX_LANES / 2;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(mask_out));

    p_quarter_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b00) |=> (mask_out[MAX_LANES-1:QL] == '0));

    p_half_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b01) |=> (mask_out[MAX_LANES-1:HL] == '0));

    p_zeroing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wmask_en) |=> ((mask_out & ~$past(wmask)) == '0));

    p_const_false_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_imm[2:0] == 3'd3) |=> (mask_out == '0));

    p_const_true_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_imm[2:0] == 3'd7 && !wmask_en && vlen_sel[1])
        |=> (mask_out == '1));

    p_self_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_imm[2:0] == 3'd0 && src_a == src_b && !bcast
         && !wmask_en && vlen_sel[1]) |=> (mask_out == '1));

endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(
    .MAX_LANES (MAX_LANES),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .pred_imm  (pred_imm),
    .vlen_sel  (vlen_sel),
    .wmask_en  (wmask_en),
    .wmask     (wmask),
    .bcast     (bcast),
    .mask_out  (mask_out),
    .out_valid (out_valid)
);

// File: tb/vcmp_mask_unit_test.sv
`timescale 1ns/1ps
// Self-checking bench for vcmp_mask_unit: sweeps relation codes, signedness,
// lengths, writemasks and broadcast over boundary-value lane crosses.
module vcmp_mask_unit_test;

    localparam int NL = 16;
    localparam int VW = 32 * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [VW-1:0] src_a;
    logic [VW-1:0] src_b;
    logic [7:0]    pred_imm;
    logic          is_signed;
    logic [1:0]    vlen_sel;
    logic          wmask_en;
    logic [NL-1:0] wmask;
    logic          bcast;
    logic          b_is_mem;
    logic [NL-1:0] mask_out;
    logic          out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] bv [4];

    vcmp_mask_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .pred_imm(pred_imm),
        .is_signed(is_signed), .vlen_sel(vlen_sel), .wmask_en(wmask_en),
        .wmask(wmask), .bcast(bcast), .b_is_mem(b_is_mem),
        .mask_out(mask_out), .out_valid(out_valid)
    );

    always #10 clk = ~clk;

    // Reference result computed directly from the requirements.
    function automatic logic [NL-1:0] model(
        input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [7:0] p,
        input logic sg, input logic [1:0] vs, input logic we,
        input logic [NL-1:0] wm, input logic bc, input logic mem);
        logic [NL-1:0] r;
        int lanes;
        lanes = (vs == 2'b00) ? 4 : (vs == 2'b01) ? 8 : 16;
        r = '0;
        for (int j = 0; j < NL; j++) begin
            logic [31:0] x, y;
            logic eq, lt, h;
            x  = a[32*j +: 32];
            y  = (bc && mem) ? b[31:0] : b[32*j +: 32];
            eq = (x == y);
            lt = sg ? ($signed(x) < $signed(y)) : (x < y);
            case (p[2:0])
                3'd0: h = eq;
                3'd1: h = lt;
                3'd2: h = lt | eq;
                3'd3: h = 1'b0;
                3'd4: h = !eq;
                3'd5: h = !lt;
                3'd6: h = !(lt | eq);
                default: h = 1'b1;
            endcase
            if (j >= lanes) h = 1'b0;
            if (we && !wm[j]) h = 1'b0;
            r[j] = h;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NL-1:0] exp_m,
                         input logic exp_v);
        n_checks++;
        if (mask_out !== exp_m || out_valid !== exp_v) begin
            n_fails++;
            $display("FAIL %s: mask=%h valid=%b expected mask=%h valid=%b",
                     tag, mask_out, out_valid, exp_m, exp_v);
        end
    endtask

    // Drive one request at a falling edge and check it one edge later.
    task automatic op(input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [7:0] p, input logic sg, input logic [1:0] vs,
                      input logic we, input logic [NL-1:0] wm, input logic bc,
                      input logic mem, input string tag);
        logic [NL-1:0] e;
        @(negedge clk);
        src_a = a; src_b = b; pred_imm = p; is_signed = sg; vlen_sel = vs;
        wmask_en = we; wmask = wm; bcast = bc; b_is_mem = mem; in_valid = 1'b1;
        e = model(a, b, p, sg, vs, we, wm, bc, mem);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, e, 1'b1);
    endtask

    // Lane j holds the pair (bv[j/4], bv[j%4]): every ordered boundary pair.
    task automatic make_cross(output logic [VW-1:0] a, output logic [VW-1:0] b);
        for (int j = 0; j < NL; j++) begin
            a[32*j +: 32] = bv[(j / 4) % 4];
            b[32*j +: 32] = bv[j % 4];
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [VW-1:0] a, b;
        logic [NL-1:0] last;
        bv[0] = 32'h0000_0000; bv[1] = 32'h7FFF_FFFF;
        bv[2] = 32'h8000_0000; bv[3] = 32'hFFFF_FFFF;
        rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0; pred_imm = '0;
        is_signed = 1'b0; vlen_sel = 2'b10; wmask_en = 1'b0; wmask = '0;
        bcast = 1'b0; b_is_mem = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset state", '0, 1'b0);
        rst_n = 1'b1;

        // R1 R3 R4: every relation code in both signedness modes.
        make_cross(a, b);
        for (int p = 0; p < 8; p++)
            for (int s = 0; s < 2; s++)
                op(a, b, 8'(p), 1'(s), 2'b10, 1'b0, '0, 1'b0, 1'b0,
                   "R1 R3 R4 relation sweep");

        // R2: reserved predicate bits set to random values.
        for (int p = 0; p < 8; p++)
            op(a, b, {5'($urandom_range(1, 31)), 3'(p)}, 1'(p & 1), 2'b10,
               1'b0, '0, 1'b0, 1'b0, "R2 reserved bits");

        // R7: broadcast lane 0 of B, each boundary value, both signedness modes.
        for (int k = 0; k < 4; k++)
            for (int p = 1; p < 3; p++) begin
                logic [VW-1:0] bb;
                bb = {VW{1'b0}};
                for (int j = 0; j < NL; j++) bb[32*j +: 32] = $urandom;
                bb[31:0] = bv[k];
                op(a, bb, 8'(p), 1'(p & 1), 2'b10, 1'b0, '0, 1'b1, 1'b1,
                   "R7 broadcast");
                op(a, bb, 8'(p), 1'(p & 1), 2'b10, 1'b0, '0, 1'b1, 1'b0,
                   "R7 broadcast needs memory operand");
            end

        // R5: each length select with random data in all lanes.
        for (int v = 0; v < 4; v++)
            for (int p = 5; p < 8; p++) begin
                logic [VW-1:0] ra, rb;
                for (int j = 0; j < NL; j++) begin
                    ra[32*j +: 32] = $urandom;
                    rb[32*j +: 32] = $urandom;
                end
                op(ra, rb, 8'(p), 1'(v & 1), 2'(v), 1'b0, '0, 1'b0, 1'b0,
                   "R5 lane count");
            end

        // R6: random writemask, enabled and disabled.
        for (int t = 0; t < 8; t++) begin
            logic [NL-1:0] wm;
            wm = NL'($urandom);
            op(a, b, 8'(t), 1'(t & 1), 2'b10, 1'b1, wm, 1'b0, 1'b0,
               "R6 writemask zeroing");
            op(a, b, 8'(t), 1'(t & 1), 2'b10, 1'b0, wm, 1'b0, 1'b0,
               "R6 writemask disabled");
        end

        // R8: idle cycles keep the mask and drop valid.
        op(a, b, 8'd7, 1'b0, 2'b10, 1'b0, '0, 1'b0, 1'b0, "R8 request");
        last = mask_out;
        @(negedge clk);
        pred_imm = 8'd3; src_a = ~a;
        @(negedge clk);
        check("R8 hold while idle", last, 1'b0);
        @(negedge clk);
        check("R8 hold second idle cycle", last, 1'b0);

        // R9: reset mid-run clears the captured result.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears result", '0, 1'b0);
        rst_n = 1'b1;
        op(a, b, 8'd1, 1'b1, 2'b01, 1'b0, '0, 1'b0, 1'b0, "R5 R9 after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule